// File: doc/BRIEF.md
# LCD Vertical Frame Timing Generator with Phase Compare Interrupt

This block produces the line-level timing of a raster LCD frame. Each frame is split into four vertical phases: sync, back porch, active video and front porch. The block tracks which phase it is in and how many lines of that phase have passed. It moves forward one line each time the horizontal timing logic pulses a line-done strobe. Software sets the length of each phase as a line count, one field per phase. A zero field is treated as a length of one line.

A two-bit compare selector chooses one of the four phase starts as the frame event. When the chosen phase begins, a sticky status bit is set. The bit stays set until software pulses the clear input. The interrupt request is that status bit gated by an enable. The block captures the selector only at phase boundaries. A change to the selector in the middle of a phase therefore never produces a stray event.

Top module: `lcd_vert_timing`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, the block is in the sync phase at line 0. The outputs are vsync=1, active=0, cmp_status=0 and cmp_irq=0, and the captured compare selector is 00.
- R2: The phases follow the fixed order sync (code 0), back porch (code 1), active video (code 2), front porch (code 3), then back to sync, with no phase skipped.
- R3: A phase whose length field holds N ≥ 1 lasts N line-done strobes. A field of 0 behaves as a length of 1. The comparison uses the current field value, so a field lowered below the lines already counted ends the phase on the next strobe.
- R4: The line counter and the phase change only on a clock edge where line_done is high.
- R5: vsync is high exactly while the phase is sync, and active is high exactly while the phase is active video. Both update on the clock edge that accepts the line_done that ends the previous phase.
- R6: A captured selector of 00 selects the start of sync, 01 the start of the back porch, 10 the start of active video and 11 the start of the front porch. cmp_status becomes 1 on the clock edge where the selected phase begins.
- R7: Leaving reset is not a phase start, so no status is set until the first real boundary that matches the selector.
- R8: At each phase boundary, the match test uses the selector value captured at the previous boundary (00 after reset), and cmp_sel is captured again on that same edge. A change between boundaries therefore never sets the status at a boundary chosen only by the new value before the next boundary.
- R9: cmp_status stays 1 until a cycle where irq_clr is 1 and no new event occurs. If a new event and a clear fall on the same edge, the event wins and the status stays 1.
- R10: cmp_irq equals cmp_status AND irq_en at all times, with no added delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_done | input | 1 | One-cycle strobe marking the end of a horizontal line |
| sync_lines | input | CNT_W | Length of the sync phase in lines |
| back_lines | input | CNT_W | Length of the back porch in lines |
| active_lines | input | CNT_W | Length of active video in lines |
| front_lines | input | CNT_W | Length of the front porch in lines |
| cmp_sel | input | 2 | Phase-start selector for the compare event |
| irq_en | input | 1 | Interrupt enable |
| irq_clr | input | 1 | Clears the status bit (write-one pulse) |
| vsync | output | 1 | High during the sync phase |
| active | output | 1 | High during active video |
| cmp_status | output | 1 | Sticky compare-event status |
| cmp_irq | output | 1 | Interrupt request |

## Verification
The hardest cases to reach from the ports are the ones where several things meet on one edge. One is a clear that arrives on the same edge as a matching boundary. Another is a selector change that happens between two boundaries. A third is a length field lowered below the count already reached. The stimulus drives line_done, the selector, the clear and the length fields at random each cycle, with lengths kept between 0 and 3. This makes boundaries close together, so all of these overlaps happen many times. A behavioural model built on plain integers predicts every output each cycle.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
   // Phase codes double as compare selector codes.
   typedef enum logic [1:0] {
      PH_SYNC   = 2'd0,
      PH_BACK   = 2'd1,
      PH_ACTIVE = 2'd2,
      PH_FRONT  = 2'd3
   } vphase_e;

   localparam int unsigned NUM_PHASES = 4;
   localparam int unsigned PH_W       = 2;
endpackage

// File: rtl/vtg_phase_seq.sv
module vtg_phase_seq
   import vtg_pkg::*;
#(
   parameter int unsigned CNT_W = 8
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  line_done,
   input  logic [NUM_PHASES-1:0][CNT_W-1:0]      len_i,
   output vphase_e                               phase_o,
   output vphase_e                               next_o,
   output logic                                  bnd_o
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   generate
      if (CNT_W < 1) begin : g_bad_w
         $error("vtg_phase_seq: CNT_W must be at least 1");
      end
   endgenerate

   vphase_e          phase_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] len_sel;
   logic [CNT_W-1:0] last_idx;
   logic [PH_W-1:0]  nxt_raw;
   logic             is_last;
   logic             bnd;

   always_comb begin
      len_sel  = len_i[phase_q];
      last_idx = (len_sel == '0) ? '0 : (len_sel - ONE);
      is_last  = (cnt_q >= last_idx);
      bnd      = line_done & is_last;
      nxt_raw  = phase_q + PH_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_SYNC;
         cnt_q   <= '0;
      end else if (line_done) begin
         if (is_last) begin
            phase_q <= vphase_e'(nxt_raw);
            cnt_q   <= '0;
         end else begin
            cnt_q   <= cnt_q + ONE;
         end
      end
   end

   assign phase_o = phase_q;
   assign next_o  = vphase_e'(nxt_raw);
   assign bnd_o   = bnd;

   // R2: a boundary moves to the successor phase
   a_r2_phase_order: assert property (@(posedge clk) disable iff (!rst_n)
      bnd |=> (phase_q == $past(next_o)));

   // R3: a new phase starts at line 0
   a_r3_count_restart: assert property (@(posedge clk) disable iff (!rst_n)
      bnd |=> (cnt_q == '0));

   // R4: nothing moves without a line strobe
   a_r4_hold_no_line: assert property (@(posedge clk) disable iff (!rst_n)
      !line_done |=> ($stable(phase_q) && $stable(cnt_q)));
endmodule

// File: rtl/vtg_cmp_sel.sv
module vtg_cmp_sel
   import vtg_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bnd_i,
   input  vphase_e          next_i,
   input  logic [PH_W-1:0]  cmp_sel_i,
   output logic             hit_o
);
   logic [PH_W-1:0] eff_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      eff_q <= '0;
      else if (bnd_i)  eff_q <= cmp_sel_i;
   end

   assign hit_o = bnd_i && (next_i == vphase_e'(eff_q));

   // R8: captured selector only changes at boundaries
   a_r8_sel_capture_only_at_bnd: assert property (@(posedge clk) disable iff (!rst_n)
      !bnd_i |=> $stable(eff_q));
endmodule

// File: rtl/vtg_irq_stat.sv
module vtg_irq_stat #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   input  logic en_i,
   output logic status_o,
   output logic irq_o
);
   logic status_q;
   logic status_d;

   generate
      if (SET_WINS) begin : g_set_wins
         always_comb status_d = set_i | (status_q & ~clr_i);
      end else begin : g_clr_wins
         always_comb status_d = ~clr_i & (set_i | status_q);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status_q <= 1'b0;
      else        status_q <= status_d;
   end

   assign status_o = status_q;
   assign irq_o    = status_q & en_i;

   // R9: status is sticky without a clear
   a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (status_q && !clr_i) |=> status_q);

   generate
      if (SET_WINS) begin : g_set_chk
         // R9: an event always leaves the status set
         a_r9_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
            set_i |=> status_q);
      end
   endgenerate
endmodule

// File: rtl/lcd_vert_timing.sv
module lcd_vert_timing
   import vtg_pkg::*;
#(
   parameter int unsigned CNT_W    = 8,
   parameter bit          SET_WINS = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             line_done,
   input  logic [CNT_W-1:0] sync_lines,
   input  logic [CNT_W-1:0] back_lines,
   input  logic [CNT_W-1:0] active_lines,
   input  logic [CNT_W-1:0] front_lines,
   input  logic [1:0]       cmp_sel,
   input  logic             irq_en,
   input  logic             irq_clr,
   output logic             vsync,
   output logic             active,
   output logic             cmp_status,
   output logic             cmp_irq
);
   logic [NUM_PHASES-1:0][CNT_W-1:0] lens;
   vphase_e phase;
   vphase_e nxt;
   logic    bnd;
   logic    hit;

   always_comb begin
      lens[PH_SYNC]   = sync_lines;
      lens[PH_BACK]   = back_lines;
      lens[PH_ACTIVE] = active_lines;
      lens[PH_FRONT]  = front_lines;
   end

   vtg_phase_seq #(.CNT_W(CNT_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .line_done (line_done),
      .len_i     (lens),
      .phase_o   (phase),
      .next_o    (nxt),
      .bnd_o     (bnd)
   );

   vtg_cmp_sel u_cmp (
      .clk       (clk),
      .rst_n     (rst_n),
      .bnd_i     (bnd),
      .next_i    (nxt),
      .cmp_sel_i (cmp_sel),
      .hit_o     (hit)
   );

   vtg_irq_stat #(.SET_WINS(SET_WINS)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_i    (hit),
      .clr_i    (irq_clr),
      .en_i     (irq_en),
      .status_o (cmp_status),
      .irq_o    (cmp_irq)
   );

   assign vsync  = (phase == PH_SYNC);
   assign active = (phase == PH_ACTIVE);

   // R5: vsync falls only when a line ends
   a_r5_vsync_on_line: assert property (@(posedge clk) disable iff (!rst_n)
      !line_done |=> $stable(vsync) && $stable(active));

   // R6: the status rises only on a line strobe edge
   a_r6_rise_on_line: assert property (@(posedge clk) disable iff (!rst_n)
      (!line_done && !cmp_status) |=> !cmp_status);
endmodule

// File: tb/tb_lcd_vert_timing.sv
module tb_lcd_vert_timing;
   localparam int CW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          line_done = 1'b0;
   logic [CW-1:0] sync_lines = 8'd1, back_lines = 8'd1, active_lines = 8'd1, front_lines = 8'd1;
   logic [1:0]    cmp_sel = 2'd0;
   logic          irq_en = 1'b0, irq_clr = 1'b0;
   logic          vsync, active, cmp_status, cmp_irq;

   lcd_vert_timing #(.CNT_W(CW)) dut (
      .clk(clk), .rst_n(rst_n), .line_done(line_done),
      .sync_lines(sync_lines), .back_lines(back_lines),
      .active_lines(active_lines), .front_lines(front_lines),
      .cmp_sel(cmp_sel), .irq_en(irq_en), .irq_clr(irq_clr),
      .vsync(vsync), .active(active), .cmp_status(cmp_status), .cmp_irq(cmp_irq)
   );

   always #4 clk = ~clk;

   int    vectors = 0;
   int    miscompares = 0;
   string tag = "R1";
   bit    finished = 1'b0;

   // Behavioural reference model
   int m_ph = 0, m_cnt = 0, m_sel = 0;
   bit m_st = 1'b0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ph = 0; m_cnt = 0; m_sel = 0; m_st = 1'b0;
      end else begin
         int len;
         bit hit;
         hit = 1'b0;
         case (m_ph)
            0: len = int'(sync_lines);
            1: len = int'(back_lines);
            2: len = int'(active_lines);
            default: len = int'(front_lines);
         endcase
         if (len == 0) len = 1;
         if (line_done) begin
            if (m_cnt + 1 >= len) begin
               m_ph  = (m_ph + 1) % 4;
               hit   = (m_ph == m_sel);
               m_sel = int'(cmp_sel);
               m_cnt = 0;
            end else begin
               m_cnt++;
            end
         end
         if (hit) m_st = 1'b1;
         else if (irq_clr) m_st = 1'b0;
      end
   end

   task automatic chk1(string req, string nm, logic act, logic exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s %s actual=%b expected=%b at %0t", req, nm, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      chk1({tag, "/R5"}, "vsync", vsync, m_ph == 0);
      chk1({tag, "/R5"}, "active", active, m_ph == 2);
      chk1({tag, "/R6"}, "cmp_status", cmp_status, m_st);
      chk1({tag, "/R10"}, "cmp_irq", cmp_irq, m_st & irq_en);
   endtask

   task automatic cycle(bit ld, bit clr);
      @(negedge clk);
      compare_all();
      line_done = ld;
      irq_clr   = clr;
   endtask

   task automatic set_lens(int a, int b, int c, int d);
      sync_lines = CW'(a); back_lines = CW'(b);
      active_lines = CW'(c); front_lines = CW'(d);
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
   endtask

   initial begin
      #(8 * 150000);
      if (!finished) begin
         miscompares++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end

   initial begin
      // R1: reset state
      tag = "R1";
      set_lens(2, 3, 4, 1);
      repeat (3) cycle(1'b1, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      line_done = 1'b0;
      cycle(1'b0, 1'b0);
      chk1("R1", "vsync after reset", vsync, 1'b1);
      chk1("R1", "status after reset", cmp_status, 1'b0);

      // R2: continuous line strobes, fixed lengths
      tag = "R2";
      irq_en = 1'b1;
      for (int i = 0; i < 60; i++) cycle(1'b1, (i % 11) == 10);

      // R4: sparse line strobes
      tag = "R4";
      for (int i = 0; i < 80; i++) cycle(($urandom % 10) < 3, 1'b0);

      // R6: each selector code in turn
      tag = "R6";
      for (int s = 0; s < 4; s++) begin
         cmp_sel = 2'(s);
         for (int i = 0; i < 60; i++) cycle(i[0], (i % 9) == 0);
      end

      // R3: zero lengths act as one line
      tag = "R3";
      set_lens(0, 2, 0, 3);
      for (int i = 0; i < 60; i++) cycle(1'b1, (i % 5) == 0);

      // R8: selector changes between boundaries
      tag = "R8";
      set_lens(3, 2, 3, 2);
      for (int i = 0; i < 200; i++) begin
         cmp_sel = 2'($urandom % 4);
         cycle(($urandom % 2) == 0, ($urandom % 4) == 0);
      end

      // R9: clears colliding with events
      tag = "R9";
      set_lens(1, 1, 1, 1);
      for (int i = 0; i < 300; i++) cycle(1'b1, ($urandom % 2) == 0);

      // R10: enable toggling
      tag = "R10";
      for (int i = 0; i < 200; i++) begin
         irq_en = ($urandom % 2) == 0;
         cycle(($urandom % 2) == 0, ($urandom % 6) == 0);
      end

      // R7: second reset, long phases, no event at reset exit
      tag = "R7";
      set_lens(6, 6, 6, 6);
      cmp_sel = 2'd0;
      irq_en = 1'b1;
      @(negedge clk);
      rst_n = 1'b0;
      cycle(1'b0, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < 5; i++) cycle(1'b1, 1'b0);
      chk1("R7", "no status after reset exit", cmp_status, 1'b0);
      for (int i = 0; i < 40; i++) cycle(1'b1, 1'b0);

      // Mixed random traffic with length changes mid-phase (R3, R8, R9)
      tag = "R2";
      for (int i = 0; i < 4000; i++) begin
         if (($urandom % 16) == 0)
            set_lens($urandom % 4, $urandom % 4, $urandom % 4, $urandom % 4);
         if (($urandom % 5) == 0) cmp_sel = 2'($urandom % 4);
         irq_en = ($urandom % 8) != 0;
         cycle(($urandom % 3) != 0, ($urandom % 5) == 0);
      end

      finished = 1'b1;
      summary();
      $finish;
   end
endmodule